// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Init Sequencer

This block owns two jobs for an EDO DRAM array: it runs the power-up start sequence and the periodic refresh that keeps the array's contents valid. After reset it keeps every strobe inactive for a fixed quiet period. It then runs a burst of dummy refresh cycles and raises a sticky ready flag. From then on it issues one CAS-before-RAS refresh each time a programmable interval expires.

The block does not own the DRAM bus. Whenever it has refresh work, it raises a request to the access controller and waits for a grant. While the grant is held, it drives the row strobe, all column strobes together, and the write enable. If the bus is busy, refreshes that fall due are counted as pending, up to a parameterized limit. They are issued back to back once the grant arrives. The block never drives the address or data pins. Address and output enable are don't-care during these cycles, and the data bus stays high-impedance.

Each refresh is a fixed strobe pattern whose phase lengths are parameters given in clock cycles. The column strobes fall first. The row strobe falls while they are low. Both rise together, and a precharge period with everything high follows. Write enable stays high the whole time.

Top module: `refresh_init_seq`

## Requirements
- R1: For INIT_WAIT_CYC cycles after reset is released, rasN and every casN line stay high (1 = inactive), busReq stays 0 and initDone stays 0.
- R2: Once the quiet period ends, exactly DUMMY_COUNT refresh cycles run. initDone rises after the last one completes.
- R3: In every refresh, all CAS_LINES casN lines have the same value at all times. They go low exactly SETUP_CYC cycles before rasN goes low, stay low for the whole rasN-low window, and return high in the same cycle as rasN.
- R4: rasN stays low for exactly LOW_CYC cycles per refresh. Before casN falls again, rasN and casN are both high for at least PRE_CYC cycles. weN is 1 at all times.
- R5: busReq is 1 while refresh work is outstanding or a refresh is in progress, and 0 otherwise. A refresh starts only when busGrant is 1 while the block is idle. With busGrant at 0, rasN never falls.
- R6: After initDone, one refresh falls due every refIntervalCfg cycles. A refIntervalCfg of 0 stops periodic refresh.
- R7: Refreshes that fall due without a grant accumulate up to MAX_PENDING, and further ones are dropped. Once the grant is given, all accumulated refreshes are issued back to back.
- R8: A refresh falling due in the same cycle as another refresh completes is neither lost nor counted twice.
- R9: initDone, once set, stays 1 until reset. A reset at any time returns the block to its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIntervalCfg | input | IVL_W | Refresh interval in cycles; 0 disables periodic refresh |
| busGrant | input | 1 | Bus grant from the access controller |
| busReq | output | 1 | Bus request to the access controller |
| rasN | output | 1 | Row strobe, active low |
| casN | output | CAS_LINES | Column strobes, active low, switched together |
| weN | output | 1 | Write enable, active low, held high |
| initDone | output | 1 | Sticky flag: the memory may be used |

## Verification
The interval timer can declare a new refresh due in the same cycle that the sequencer retires one, so the pending count must both add and subtract on a single edge. The bench forces this coincidence on every refresh. It sets the interval equal to the length of one refresh plus its idle cycle and holds the grant high continuously, which keeps the due tick and the completion locked to the same edge. It judges the result by counting row-strobe falls over a 500-cycle window: a lost due would stop the refresh stream, and a doubled one would let pending grow, so the count must stay at one refresh per interval. The strobe monitor checks the edge ordering and widths of every cycle during this run as well.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_PRE   = 2'd3
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic   phaseLoad;
    phase_t loadPhase;
    logic   cycleDone;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic waitDone;
    logic workAvail;
    logic phaseEnd;
  } seqStatus_t;

endpackage

// File: rtl/refseq_datapath.sv
module refseq_datapath
  import refseq_pkg::*;
#(
  parameter int INIT_WAIT_CYC = 10000,
  parameter int DUMMY_COUNT   = 8,
  parameter int SETUP_CYC     = 1,
  parameter int LOW_CYC       = 5,
  parameter int PRE_CYC       = 3,
  parameter int MAX_PENDING   = 4,
  parameter int IVL_W         = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IVL_W-1:0] refIntervalCfg,
  input  seqStrobe_t       strobe,
  output seqStatus_t       status,
  output logic             initDone
);

  localparam int WAIT_W = $clog2(INIT_WAIT_CYC + 1);
  localparam int DUM_W  = $clog2(DUMMY_COUNT + 1);
  localparam int PEND_W = $clog2(MAX_PENDING + 1);
  localparam int PH_MAX = (SETUP_CYC > LOW_CYC)
                          ? ((SETUP_CYC > PRE_CYC) ? SETUP_CYC : PRE_CYC)
                          : ((LOW_CYC > PRE_CYC) ? LOW_CYC : PRE_CYC);
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic [WAIT_W-1:0] waitCnt;
  logic              waitDoneQ;
  logic [DUM_W-1:0]  dummyLeft;
  logic              initDoneQ;
  logic [IVL_W-1:0]  ivlCnt;
  logic [PEND_W-1:0] pending;
  logic [PH_W-1:0]   phaseCnt;
  logic              tick;
  logic              drain;

  // power-up quiet period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt   <= '0;
      waitDoneQ <= 1'b0;
    end else if (!waitDoneQ) begin
      if (waitCnt == WAIT_W'(INIT_WAIT_CYC - 1)) waitDoneQ <= 1'b1;
      else                                       waitCnt   <= waitCnt + 1'b1;
    end
  end

  // dummy burst counter and sticky ready flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dummyLeft <= DUM_W'(DUMMY_COUNT);
      initDoneQ <= 1'b0;
    end else if (strobe.cycleDone && dummyLeft != '0) begin
      dummyLeft <= dummyLeft - 1'b1;
      if (dummyLeft == DUM_W'(1)) initDoneQ <= 1'b1;
    end
  end

  // refresh interval timer
  assign tick = initDoneQ && (refIntervalCfg != '0) &&
                (ivlCnt >= (refIntervalCfg - IVL_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                            ivlCnt <= '0;
    else if (!initDoneQ || refIntervalCfg == '0 || tick)  ivlCnt <= '0;
    else                                                  ivlCnt <= ivlCnt + 1'b1;
  end

  // pending refresh counter, saturating
  assign drain = strobe.cycleDone && (dummyLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else begin
      unique case ({tick, drain})
        2'b10:   if (pending != PEND_W'(MAX_PENDING)) pending <= pending + 1'b1;
        2'b01:   if (pending != '0) pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end

  // phase length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseCnt <= '0;
    else if (strobe.phaseLoad) begin
      unique case (strobe.loadPhase)
        PH_SETUP: phaseCnt <= PH_W'(SETUP_CYC - 1);
        PH_LOW:   phaseCnt <= PH_W'(LOW_CYC - 1);
        default:  phaseCnt <= PH_W'(PRE_CYC - 1);
      endcase
    end else if (phaseCnt != '0) phaseCnt <= phaseCnt - 1'b1;
  end

  assign status.waitDone  = waitDoneQ;
  assign status.workAvail = waitDoneQ && ((dummyLeft != '0) || (pending != '0));
  assign status.phaseEnd  = (phaseCnt == '0);
  assign initDone         = initDoneQ;

  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDoneQ |=> initDoneQ); // R9
  AST_PEND_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (pending == PEND_W'(MAX_PENDING) && tick && !drain) |=> pending == PEND_W'(MAX_PENDING)); // R7
  AST_TICK_AND_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (tick && drain) |=> $stable(pending)); // R8
  AST_NO_DUE_BEFORE_READY: assert property (@(posedge clk) disable iff (!rstN)
    !initDoneQ |=> pending == '0); // R6

endmodule

// File: rtl/refseq_ctrl.sv
module refseq_ctrl
  import refseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busGrant,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       busReq,
  output logic       rasN,
  output logic       casAllN,
  output logic       weN
);

  phase_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    strobe.loadPhase = PH_IDLE;
    unique case (state)
      PH_IDLE: if (status.workAvail && busGrant) begin
        strobe.phaseLoad = 1'b1;
        strobe.loadPhase = PH_SETUP;
        stateNext        = PH_SETUP;
      end
      PH_SETUP: if (status.phaseEnd) begin
        strobe.phaseLoad = 1'b1;
        strobe.loadPhase = PH_LOW;
        stateNext        = PH_LOW;
      end
      PH_LOW: if (status.phaseEnd) begin
        strobe.phaseLoad = 1'b1;
        strobe.loadPhase = PH_PRE;
        stateNext        = PH_PRE;
      end
      default: if (status.phaseEnd) begin
        strobe.cycleDone = 1'b1;
        stateNext        = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= stateNext;
  end

  assign busReq  = (state != PH_IDLE) || status.workAvail;
  assign rasN    = (state != PH_LOW);
  assign casAllN = !((state == PH_SETUP) || (state == PH_LOW));
  assign weN     = 1'b1;

  AST_QUIET_AT_POWERUP: assert property (@(posedge clk) disable iff (!rstN)
    !status.waitDone |-> (rasN && casAllN && !busReq)); // R1
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> ($past(casAllN) == 1'b0)); // R3
  AST_CAS_HELD_TO_RAS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (($past(casAllN) == 1'b0) && casAllN)); // R3
  AST_NO_START_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE && !busGrant) |=> state == PH_IDLE); // R5
  AST_REQ_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (state != PH_IDLE) |-> busReq); // R5

endmodule

// File: rtl/refresh_init_seq.sv
module refresh_init_seq
  import refseq_pkg::*;
#(
  parameter int CAS_LINES     = 8,
  parameter int INIT_WAIT_CYC = 10000,
  parameter int DUMMY_COUNT   = 8,
  parameter int SETUP_CYC     = 1,
  parameter int LOW_CYC       = 5,
  parameter int PRE_CYC       = 3,
  parameter int MAX_PENDING   = 4,
  parameter int IVL_W         = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IVL_W-1:0]     refIntervalCfg,
  input  logic                 busGrant,
  output logic                 busReq,
  output logic                 rasN,
  output logic [CAS_LINES-1:0] casN,
  output logic                 weN,
  output logic                 initDone
);

  seqStrobe_t strobe;
  seqStatus_t status;
  logic       casAllN;

  refseq_datapath #(
    .INIT_WAIT_CYC(INIT_WAIT_CYC),
    .DUMMY_COUNT  (DUMMY_COUNT),
    .SETUP_CYC    (SETUP_CYC),
    .LOW_CYC      (LOW_CYC),
    .PRE_CYC      (PRE_CYC),
    .MAX_PENDING  (MAX_PENDING),
    .IVL_W        (IVL_W)
  ) datapath_i (
    .clk           (clk),
    .rstN          (rstN),
    .refIntervalCfg(refIntervalCfg),
    .strobe        (strobe),
    .status        (status),
    .initDone      (initDone)
  );

  refseq_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busGrant(busGrant),
    .status  (status),
    .strobe  (strobe),
    .busReq  (busReq),
    .rasN    (rasN),
    .casAllN (casAllN),
    .weN     (weN)
  );

  // every column strobe line follows the one shared control bit
  for (genvar g = 0; g < CAS_LINES; g++) begin : gCasFan
    assign casN[g] = casAllN;
  end

endmodule

// File: tb/refresh_init_seq_tb_top.sv
module refresh_init_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CASN       = 8;
  localparam int INIT_W     = 200;
  localparam int DUMMIES    = 8;
  localparam int SET_C      = 1;
  localparam int LOW_C      = 5;
  localparam int PRE_C      = 3;
  localparam int MAXP       = 4;
  localparam int VEC_N      = 5;
  // {interval, intervals held without grant, expected refreshes}
  localparam int VEC [VEC_N][3] = '{
    '{100, 1, 1}, '{100, 2, 2}, '{60, 4, 4}, '{60, 7, 4}, '{100, 5, 4}};

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [15:0]     cfg = 16'd100;
  logic            busGrant = 1'b0;
  logic            busReq, rasN, weN, initDone;
  logic [CASN-1:0] casN;

  int total = 0, bad = 0;
  int rasFalls = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_init_seq #(
    .CAS_LINES(CASN), .INIT_WAIT_CYC(INIT_W), .DUMMY_COUNT(DUMMIES),
    .SETUP_CYC(SET_C), .LOW_CYC(LOW_C), .PRE_CYC(PRE_C),
    .MAX_PENDING(MAXP), .IVL_W(16)
  ) dut_i (
    .clk(clk), .rstN(rstN), .refIntervalCfg(cfg), .busGrant(busGrant),
    .busReq(busReq), .rasN(rasN), .casN(casN), .weN(weN), .initDone(initDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // strobe-shape monitor, sampled away from the active edge
  int casLowRun = 0, rasLowRun = 0, highRun = 100;
  bit prevRas = 1'b1, prevCasHigh = 1'b1, initSeen = 1'b0;
  always @(negedge clk) begin
    if (!rstN) begin
      casLowRun = 0; rasLowRun = 0; highRun = 100;
      prevRas = 1'b1; prevCasHigh = 1'b1; initSeen = 1'b0;
    end else begin
      if (!(casN == '0 || casN == '1)) check(1'b0, "R3 cas lines split", int'(casN), 0);
      if (weN !== 1'b1) check(1'b0, "R4 weN high", int'(weN), 1);
      if (initSeen && !initDone) check(1'b0, "R9 initDone sticky", 0, 1);
      if (initDone) initSeen = 1'b1;
      if (prevCasHigh && casN == '0)
        check(highRun >= PRE_C, "R4 precharge before cas fall", highRun, PRE_C);
      if (prevRas && !rasN) begin
        rasFalls++;
        check(casLowRun == SET_C, "R3 cas leads ras", casLowRun, SET_C);
      end
      if (!prevRas && rasN) begin
        check(rasLowRun == LOW_C, "R4 ras low width", rasLowRun, LOW_C);
        check(casN == '1, "R3 cas rises with ras", int'(casN), int'(8'hFF));
      end
      if (casN == '0 && rasN) casLowRun++;
      else if (casN != '0) casLowRun = 0;
      if (!rasN) rasLowRun++; else rasLowRun = 0;
      if (casN == '1 && rasN) highRun++; else highRun = 0;
      prevRas = rasN;
      prevCasHigh = (casN == '1);
    end
  end

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (5) @(negedge clk);
    check(busReq == 1'b0 && rasN && casN == '1 && !initDone, "R9 reset state",
          int'({busReq, rasN, initDone}), 3'b010);
    rstN = 1'b1;
  endtask

  task automatic waitInit(output int seen);
    seen = 0;
    for (int i = 0; i < 2000 && !initDone; i++) @(negedge clk);
    seen = initDone;
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int ok;
    // ---- reset and quiet period, grant available (R1, R2)
    busGrant = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    doReset();
    @(negedge clk);
    check(!busReq && rasN && casN == '1 && !initDone, "R1 quiet after reset", int'(busReq), 0);
    rasFalls = 0;
    repeat (INIT_W - 5) @(negedge clk);
    check(rasFalls == 0 && !busReq && !initDone, "R1 no strobes during wait", rasFalls, 0);
    waitInit(ok);
    check(ok == 1, "R2 initDone rises", ok, 1);
    check(rasFalls == DUMMIES, "R2 dummy refresh count", rasFalls, DUMMIES);

    // ---- init gated by grant (R5, R2)
    busGrant = 1'b0;
    doReset();
    rasFalls = 0;
    repeat (INIT_W + 50) @(negedge clk);
    check(busReq == 1'b1, "R5 request raised for dummies", int'(busReq), 1);
    check(rasFalls == 0 && !initDone, "R5 no refresh without grant", rasFalls, 0);
    busGrant = 1'b1;
    waitInit(ok);
    check(rasFalls == DUMMIES && ok == 1, "R2 dummies after late grant", rasFalls, DUMMIES);
    @(negedge clk);
    check(busReq == 1'b0, "R5 request dropped when idle", int'(busReq), 0);

    // ---- table: accumulated refreshes (R6, R7, R5)
    busGrant = 1'b0;
    for (int v = 0; v < VEC_N; v++) begin
      cfg = 16'(VEC[v][0]);
      for (int i = 0; i < 400 && !busReq; i++) @(negedge clk);
      check(busReq == 1'b1, "R6 refresh falls due", int'(busReq), 1);
      rasFalls = 0;
      repeat ((VEC[v][1] - 1) * VEC[v][0] + 5) @(negedge clk);
      check(rasFalls == 0, "R5 held off without grant", rasFalls, 0);
      busGrant = 1'b1;
      repeat (45) @(negedge clk);
      check(rasFalls == VEC[v][2], "R7 pending refreshes issued", rasFalls, VEC[v][2]);
      check(busReq == 1'b0, "R7 backlog drained", int'(busReq), 0);
      busGrant = 1'b0;
    end

    // ---- interval 0 disables periodic refresh (R6)
    busGrant = 1'b1;
    cfg = 16'd0;
    repeat (40) @(negedge clk);
    rasFalls = 0;
    repeat (300) @(negedge clk);
    check(rasFalls == 0 && !busReq, "R6 zero interval disables", rasFalls, 0);

    // ---- due tick coincides with completion on every refresh (R8)
    cfg = 16'd10;
    repeat (30) @(negedge clk);
    rasFalls = 0;
    repeat (500) @(negedge clk);
    check(rasFalls >= 49 && rasFalls <= 51, "R8 tick and completion same cycle", rasFalls, 50);
    cfg = 16'd0;
    repeat (40) @(negedge clk);
    check(busReq == 1'b0, "R8 no surplus pending", int'(busReq), 0);

    // ---- reset mid-operation (R9, R1)
    cfg = 16'd100;
    check(initDone == 1'b1, "R9 initDone still set", int'(initDone), 1);
    doReset();
    repeat (INIT_W / 2) @(negedge clk);
    check(!initDone && !busReq && rasN, "R9 back to quiet state", int'(initDone), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule